// File: doc/BRIEF.md
# Synchronous Flash Read-then-Write Command Sequencer

This block sits on the controller side of a synchronous flash device that has a multi-bank, SDRAM-style command interface. It accepts one transaction at a time. Each transaction is a read burst followed by a write, and the block turns it into a cycle-exact command stream. The read can be cut short with a terminate command so that the last delivered element is the last one wanted. The write is always preceded by a load-command-register command carrying the write-setup code and then by an ACTIVE to the target row.

The block also drives the byte-mask (DQM) line, the enable of the controller's own DQ drivers, and two strobes: one marking valid read data and one marking cycles that take write data. The shared bus is handed from the memory to the controller without overlap. All of this timing is derived from the CAS latency latched when the transaction is accepted. An optional turnaround gap adds one idle cycle between the last read element and the write. Every cycle that is not a scheduled command issues NOP.

Cycle numbers below count from the cycle in which READ appears on `mem_cmd` (cycle 0). The following terms are used:
- n: the number of delivered read elements.
- L = CL + n - 1: the cycle of the last read element.
- T = n: the terminate slot.
- W: the WRITE cycle.

Top module: `flash_rw_seq`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in progress. A request is taken at a rising edge with `req_valid` and `req_ready` both high. READ appears in the cycle after that edge. `req_ready` stays low up to the last write-data cycle and returns high in the cycle after it. While idle, `mem_cmd` is NOP and no strobe, mask or driver enable is active.
- R2: Command codes are NOP=0, READ=1, WRITE=2, ACTIVE=3, LCR=4, BURST-TERMINATE=5, BANK-TERMINATE=6.
  - READ carries the read column on `mem_addr`. WRITE carries the write column. ACTIVE carries the row. All of these are zero-extended.
  - `mem_bank` carries the request bank for READ, ACTIVE, WRITE and BANK-TERMINATE, and is 0 otherwise. `mem_addr` is 0 for NOP and both terminate codes.
  - Every other cycle of a transaction issues NOP.
- R3: `rd_valid` is high in cycles CL through L and in no others. Here n equals `req_rd_len` when it is smaller than `req_rd_burst`, and equals `req_rd_burst` otherwise.
- R4: When `req_rd_len` < `req_rd_burst`, one terminate command is issued at cycle T = n, which is CL-1 cycles before the last wanted element. The code is BANK-TERMINATE when `req_term_bank` is 1 and BURST-TERMINATE otherwise. No terminate is issued when `req_rd_len` >= `req_rd_burst`.
- R5: WRITE is always immediately preceded by ACTIVE, and ACTIVE by LCR. LCR carries 0x40 on `mem_addr`.
- R6: W = max(L + 1 + gap, F). Here gap is `cfg_turn_gap`. F is T + 3 when a terminate is issued and 3 otherwise.
- R7: With CL of 2 or 3, `mem_dqm` is high in cycles W-2 and W-1 and low in every other cycle, including the WRITE cycle. With CL of 1, `mem_dqm` stays low throughout.
- R8: `dq_oe` and `wr_valid` are high from cycle W for `req_wr_len` cycles and low otherwise. Neither is ever high in a cycle with `rd_valid`.
- R9: CL is taken from `cfg_cas_lat` (legal values 1, 2 and 3) at the accepting edge. Changing it during a transaction does not alter that transaction's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_turn_gap | input | 1 | Add one idle cycle before WRITE |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Row opened before the write |
| req_col_rd | input | COL_W | Read start column |
| req_col_wr | input | COL_W | Write start column |
| req_rd_len | input | LEN_W | Wanted read elements (>=1) |
| req_rd_burst | input | LEN_W | Programmed read burst length (>=1) |
| req_wr_len | input | LEN_W | Write data cycles (>=1) |
| req_term_bank | input | 1 | Truncate with bank-specific terminate |
| mem_cmd | output | 3 | Command code |
| mem_addr | output | ADDR_W | Address bus |
| mem_bank | output | BANK_W | Bank select |
| mem_dqm | output | 1 | Byte mask |
| dq_oe | output | 1 | Controller DQ driver enable |
| rd_valid | output | 1 | Read data valid on DQ |
| wr_valid | output | 1 | Write data taken this cycle |

## Verification
The bench sweeps every CAS latency and gap setting over read lengths below, equal to and above the programmed burst. This covers the case where the truncation slot pushes LCR and the WRITE past the natural turnaround. A design that placed LCR from the data end alone would put it on the terminate slot at CL 1, or would issue LCR before the terminate. A mask window off by one cycle would either hide the last wanted read element or mask the first write word. The bench also catches a CL-1 design that raises DQM at all, and a design that enables its drivers one cycle early and fights the memory. Changing the CAS latency during a transaction exposes a design that reads the configuration live instead of latching it.

// File: rtl/flash_rw_pkg.sv
package flash_rw_pkg;

    typedef enum logic [2:0] {
        FCMD_NOP    = 3'd0,
        FCMD_READ   = 3'd1,
        FCMD_WRITE  = 3'd2,
        FCMD_ACTIVE = 3'd3,
        FCMD_LCR    = 3'd4,
        FCMD_BTERM  = 3'd5,
        FCMD_ATERM  = 3'd6
    } fcmd_e;

    localparam logic [7:0] WR_SETUP_CODE = 8'h40;

endpackage

// File: rtl/flash_rw_sched.sv
module flash_rw_sched #(
    parameter int LEN_W = 4,
    parameter int CNT_W = LEN_W + 3
) (
    input  logic [1:0]       cl,
    input  logic             gap,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [LEN_W-1:0] rd_burst,
    input  logic [LEN_W-1:0] wr_len,
    output logic             trunc,
    output logic [CNT_W-1:0] term_at,
    output logic [CNT_W-1:0] rd_last,
    output logic [CNT_W-1:0] wr_at,
    output logic [CNT_W-1:0] end_at
);

    logic [LEN_W-1:0] eff_len;
    logic [CNT_W-1:0] turn_slot;
    logic [CNT_W-1:0] floor_slot;

    always_comb begin
        trunc      = rd_len < rd_burst;
        eff_len    = trunc ? rd_len : rd_burst;
        term_at    = CNT_W'(eff_len);
        rd_last    = CNT_W'(cl) + CNT_W'(eff_len) - CNT_W'(1);
        turn_slot  = rd_last + CNT_W'(1) + CNT_W'(gap);
        // LCR must land after READ and after any terminate command
        floor_slot = trunc ? (term_at + CNT_W'(3)) : CNT_W'(3);
        wr_at      = (turn_slot > floor_slot) ? turn_slot : floor_slot;
        end_at     = wr_at + CNT_W'(wr_len) - CNT_W'(1);
    end

endmodule

// File: rtl/flash_rw_timer.sv
module flash_rw_timer #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        cfg_cl,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col_rd,
    input  logic [COL_W-1:0]  req_col_wr,
    input  logic              req_term_bank,
    input  logic              s_trunc,
    input  logic [CNT_W-1:0]  s_term_at,
    input  logic [CNT_W-1:0]  s_rd_last,
    input  logic [CNT_W-1:0]  s_wr_at,
    input  logic [CNT_W-1:0]  s_end_at,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt,
    output logic [1:0]        cl_q,
    output logic              trunc_q,
    output logic              term_bank_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_rd_q,
    output logic [COL_W-1:0]  col_wr_q,
    output logic [CNT_W-1:0]  term_at_q,
    output logic [CNT_W-1:0]  rd_last_q,
    output logic [CNT_W-1:0]  wr_at_q,
    output logic [CNT_W-1:0]  end_at_q
);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        cl;
        logic              trunc;
        logic              term_bank;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col_rd;
        logic [COL_W-1:0]  col_wr;
        logic [CNT_W-1:0]  term_at;
        logic [CNT_W-1:0]  rd_last;
        logic [CNT_W-1:0]  wr_at;
        logic [CNT_W-1:0]  end_at;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy      = 1'b1;
                st_d.cnt       = '0;
                st_d.cl        = cfg_cl;
                st_d.trunc     = s_trunc;
                st_d.term_bank = req_term_bank;
                st_d.bank      = req_bank;
                st_d.row       = req_row;
                st_d.col_rd    = req_col_rd;
                st_d.col_wr    = req_col_wr;
                st_d.term_at   = s_term_at;
                st_d.rd_last   = s_rd_last;
                st_d.wr_at     = s_wr_at;
                st_d.end_at    = s_end_at;
            end
        end else if (st_q.cnt == st_q.end_at) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = st_q.busy;
    assign cnt         = st_q.cnt;
    assign cl_q        = st_q.cl;
    assign trunc_q     = st_q.trunc;
    assign term_bank_q = st_q.term_bank;
    assign bank_q      = st_q.bank;
    assign row_q       = st_q.row;
    assign col_rd_q    = st_q.col_rd;
    assign col_wr_q    = st_q.col_wr;
    assign term_at_q   = st_q.term_at;
    assign rd_last_q   = st_q.rd_last;
    assign wr_at_q     = st_q.wr_at;
    assign end_at_q    = st_q.end_at;

endmodule

// File: rtl/flash_rw_decode.sv
module flash_rw_decode
    import flash_rw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 7
) (
    input  logic              busy,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        cl,
    input  logic              trunc,
    input  logic              term_bank,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col_rd,
    input  logic [COL_W-1:0]  col_wr,
    input  logic [CNT_W-1:0]  term_at,
    input  logic [CNT_W-1:0]  rd_last,
    input  logic [CNT_W-1:0]  wr_at,
    input  logic [CNT_W-1:0]  end_at,
    output logic [2:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank_out,
    output logic              dqm,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic              wr_valid
);

    fcmd_e            c;
    logic [CNT_W-1:0] lcr_at;
    logic [CNT_W-1:0] act_at;
    logic             in_write;

    always_comb begin
        lcr_at   = wr_at - CNT_W'(2);
        act_at   = wr_at - CNT_W'(1);
        c        = FCMD_NOP;
        addr     = '0;
        bank_out = '0;
        if (busy) begin
            if (cnt == '0) begin
                c        = FCMD_READ;
                addr     = ADDR_W'(col_rd);
                bank_out = bank;
            end else if (trunc && cnt == term_at) begin
                if (term_bank) begin
                    c        = FCMD_ATERM;
                    bank_out = bank;
                end else begin
                    c = FCMD_BTERM;
                end
            end else if (cnt == lcr_at) begin
                c    = FCMD_LCR;
                addr = ADDR_W'(WR_SETUP_CODE);
            end else if (cnt == act_at) begin
                c        = FCMD_ACTIVE;
                addr     = ADDR_W'(row);
                bank_out = bank;
            end else if (cnt == wr_at) begin
                c        = FCMD_WRITE;
                addr     = ADDR_W'(col_wr);
                bank_out = bank;
            end
        end
        cmd      = c;
        rd_valid = busy && (cnt >= CNT_W'(cl)) && (cnt <= rd_last);
        // mask window only needed when output mask latency matters (CL > 1)
        dqm      = busy && (cl != 2'd1) && ((cnt == lcr_at) || (cnt == act_at));
        in_write = busy && (cnt >= wr_at) && (cnt <= end_at);
        dq_oe    = in_write;
        wr_valid = in_write;
    end

endmodule

// File: rtl/flash_rw_seq.sv
module flash_rw_seq #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              cfg_turn_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col_rd,
    input  logic [COL_W-1:0]  req_col_wr,
    input  logic [LEN_W-1:0]  req_rd_len,
    input  logic [LEN_W-1:0]  req_rd_burst,
    input  logic [LEN_W-1:0]  req_wr_len,
    input  logic              req_term_bank,
    output logic [2:0]        mem_cmd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic              mem_dqm,
    output logic              dq_oe,
    output logic              rd_valid,
    output logic              wr_valid
);

    localparam int CNT_W = LEN_W + 3;

    logic             s_trunc;
    logic [CNT_W-1:0] s_term_at, s_rd_last, s_wr_at, s_end_at;

    logic              busy;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        cl_lat;
    logic              trunc_q, term_bank_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_rd_q, col_wr_q;
    logic [CNT_W-1:0]  term_at_q, rd_last_q, wr_at_q, end_at_q;

    flash_rw_sched #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_sched (
        .cl       (cfg_cas_lat),
        .gap      (cfg_turn_gap),
        .rd_len   (req_rd_len),
        .rd_burst (req_rd_burst),
        .wr_len   (req_wr_len),
        .trunc    (s_trunc),
        .term_at  (s_term_at),
        .rd_last  (s_rd_last),
        .wr_at    (s_wr_at),
        .end_at   (s_end_at)
    );

    flash_rw_timer #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) i_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .cfg_cl        (cfg_cas_lat),
        .req_bank      (req_bank),
        .req_row       (req_row),
        .req_col_rd    (req_col_rd),
        .req_col_wr    (req_col_wr),
        .req_term_bank (req_term_bank),
        .s_trunc       (s_trunc),
        .s_term_at     (s_term_at),
        .s_rd_last     (s_rd_last),
        .s_wr_at       (s_wr_at),
        .s_end_at      (s_end_at),
        .busy          (busy),
        .cnt           (cnt),
        .cl_q          (cl_lat),
        .trunc_q       (trunc_q),
        .term_bank_q   (term_bank_q),
        .bank_q        (bank_q),
        .row_q         (row_q),
        .col_rd_q      (col_rd_q),
        .col_wr_q      (col_wr_q),
        .term_at_q     (term_at_q),
        .rd_last_q     (rd_last_q),
        .wr_at_q       (wr_at_q),
        .end_at_q      (end_at_q)
    );

    flash_rw_decode #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                      .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_decode (
        .busy      (busy),
        .cnt       (cnt),
        .cl        (cl_lat),
        .trunc     (trunc_q),
        .term_bank (term_bank_q),
        .bank      (bank_q),
        .row       (row_q),
        .col_rd    (col_rd_q),
        .col_wr    (col_wr_q),
        .term_at   (term_at_q),
        .rd_last   (rd_last_q),
        .wr_at     (wr_at_q),
        .end_at    (end_at_q),
        .cmd       (mem_cmd),
        .addr      (mem_addr),
        .bank_out  (mem_bank),
        .dqm       (mem_dqm),
        .dq_oe     (dq_oe),
        .rd_valid  (rd_valid),
        .wr_valid  (wr_valid)
    );

    assign req_ready = !busy;

endmodule

// File: rtl/flash_rw_seq_chk.sv
module flash_rw_seq_chk
    import flash_rw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mem_cmd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dqm,
    input logic              dq_oe,
    input logic              rd_valid,
    input logic              wr_valid,
    input logic              req_ready,
    input logic [1:0]        cl_q
);

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cmd == FCMD_NOP) && !dq_oe && !rd_valid && !mem_dqm);

    p_write_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == FCMD_WRITE) |-> ($past(mem_cmd) == FCMD_ACTIVE) && ($past(mem_cmd, 2) == FCMD_LCR));

    p_lcr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == FCMD_LCR) |-> (mem_addr == ADDR_W'(WR_SETUP_CODE)));

    p_dqm_low_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == FCMD_WRITE) |-> !mem_dqm);

    p_dqm_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == FCMD_WRITE && cl_q != 2'd1) |-> ($past(mem_dqm) && $past(mem_dqm, 2)));

    p_dqm_cl1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && cl_q == 2'd1) |-> !mem_dqm);

    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && (dq_oe || wr_valid)));

    p_oe_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (mem_cmd == FCMD_WRITE));

endmodule

bind flash_rw_seq flash_rw_seq_chk #(.ADDR_W(ADDR_W)) i_flash_rw_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cmd   (mem_cmd),
    .mem_addr  (mem_addr),
    .mem_dqm   (mem_dqm),
    .dq_oe     (dq_oe),
    .rd_valid  (rd_valid),
    .wr_valid  (wr_valid),
    .req_ready (req_ready),
    .cl_q      (cl_lat)
);

// File: tb/test_flash_rw_seq.sv
module test_flash_rw_seq;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 8;
    localparam int ADDR_W = 12;
    localparam int LEN_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_cas_lat = 2'd1;
    logic              cfg_turn_gap = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col_rd = '0;
    logic [COL_W-1:0]  req_col_wr = '0;
    logic [LEN_W-1:0]  req_rd_len = 4'd1;
    logic [LEN_W-1:0]  req_rd_burst = 4'd1;
    logic [LEN_W-1:0]  req_wr_len = 4'd1;
    logic              req_term_bank = 1'b0;
    logic [2:0]        mem_cmd;
    logic [ADDR_W-1:0] mem_addr;
    logic [BANK_W-1:0] mem_bank;
    logic              mem_dqm;
    logic              dq_oe;
    logic              rd_valid;
    logic              wr_valid;

    int checks = 0;
    int errors = 0;
    int txn_id = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flash_rw_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
                   .ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_flash_rw_seq (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_turn_gap(cfg_turn_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_row(req_row),
        .req_col_rd(req_col_rd), .req_col_wr(req_col_wr), .req_rd_len(req_rd_len),
        .req_rd_burst(req_rd_burst), .req_wr_len(req_wr_len), .req_term_bank(req_term_bank),
        .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_dqm(mem_dqm),
        .dq_oe(dq_oe), .rd_valid(rd_valid), .wr_valid(wr_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s txn=%0d actual=%0d expected=%0d", tag, txn_id, act, exp);
        end
    endtask

    // one transaction; expected timeline derived from the requirement formulas
    task automatic run_txn(input int cl, input int gap, input int burst, input int len,
                           input int wrl, input int tbank, input bit perturb);
        int trunc, n, last, tslot, w, e, fl, bank, row, crd, cwr;
        int ecmd, eaddr, ebank;
        string ctag;
        trunc = (len < burst) ? 1 : 0;
        n     = trunc ? len : burst;
        last  = cl + n - 1;
        tslot = n;
        fl    = trunc ? tslot + 3 : 3;
        w     = (last + 1 + gap > fl) ? last + 1 + gap : fl;
        e     = w + wrl - 1;
        bank  = txn_id % 4;
        row   = (txn_id * 37 + 5) % 4096;
        crd   = (txn_id * 11 + 3) % 256;
        cwr   = (txn_id * 29 + 7) % 256;

        @(negedge clk);
        chk("R1 ready before request", int'(req_ready), 1);
        cfg_cas_lat   = 2'(cl);
        cfg_turn_gap  = gap[0];
        req_bank      = BANK_W'(bank);
        req_row       = ROW_W'(row);
        req_col_rd    = COL_W'(crd);
        req_col_wr    = COL_W'(cwr);
        req_rd_len    = LEN_W'(len);
        req_rd_burst  = LEN_W'(burst);
        req_wr_len    = LEN_W'(wrl);
        req_term_bank = tbank[0];
        req_valid     = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= e + 1; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            // R9: live configuration change must not disturb this transaction
            if (perturb && k == 1) cfg_cas_lat = 2'((cl % 3) + 1);
            if (k > e) begin
                chk("R1 ready after last write cycle", int'(req_ready), 1);
                chk("R1 idle command", int'(mem_cmd), 0);
            end else begin
                ecmd = 0; eaddr = 0; ebank = 0; ctag = "R2 nop slot";
                if (k == 0) begin
                    ecmd = 1; eaddr = crd; ebank = bank; ctag = "R1 read slot";
                end else if (trunc == 1 && k == tslot) begin
                    ecmd = tbank ? 6 : 5; ebank = tbank ? bank : 0; ctag = "R4 terminate slot";
                end else if (k == w - 2) begin
                    ecmd = 4; eaddr = 64; ctag = "R5 lcr slot";
                end else if (k == w - 1) begin
                    ecmd = 3; eaddr = row; ebank = bank; ctag = "R5 active slot";
                end else if (k == w) begin
                    ecmd = 2; eaddr = cwr; ebank = bank; ctag = "R6 write slot";
                end
                chk(ctag, int'(mem_cmd), ecmd);
                chk("R2 address", int'(mem_addr), eaddr);
                chk("R2 bank", int'(mem_bank), ebank);
                chk(perturb ? "R9 read valid" : "R3 read valid", int'(rd_valid),
                    (k >= cl && k <= last) ? 1 : 0);
                chk("R7 dqm", int'(mem_dqm), (cl > 1 && (k == w - 2 || k == w - 1)) ? 1 : 0);
                chk("R8 dq_oe", int'(dq_oe), (k >= w && k <= e) ? 1 : 0);
                chk("R8 wr_valid", int'(wr_valid), (k >= w && k <= e) ? 1 : 0);
                chk("R1 ready busy", int'(req_ready), 0);
            end
        end
        txn_id++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", int'(req_ready), 1);
        chk("R1 reset cmd", int'(mem_cmd), 0);
        chk("R1 reset dqm", int'(mem_dqm), 0);
        chk("R1 reset oe", int'(dq_oe), 0);
        chk("R1 reset rd_valid", int'(rd_valid), 0);
        for (int cl = 1; cl <= 3; cl++) begin
            for (int gap = 0; gap <= 1; gap++) begin
                for (int bi = 0; bi <= 3; bi++) begin
                    for (int len = 1; len <= (1 << bi) + 1; len++) begin
                        run_txn(cl, gap, 1 << bi, len, (len % 3) + 1, len % 2, len == 1);
                    end
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule